// File: doc/BRIEF.md
# Security State Attribution Checker

This block assigns one of three security attributes to every memory access: Secure, Non-secure-Callable or Non-secure. It then decides whether the access is allowed for the processor's current security state. A small bank of programmable address windows sets the attributes. Each window holds an inclusive lower and upper bound, an enable bit and a 2-bit attribute code. The lowest-numbered enabled window that matches the address sets the attribute. An address that no window matches is treated as Secure.

The block also holds the processor security state in a dedicated bit. This bit is separate from execution mode and privilege level. A Non-secure caller can enter Secure state in only one way: it fetches an instruction with the gateway flag set from a Callable address. A gateway opcode in plain Secure memory is only a faulting access. A separate one-cycle input pulse returns the processor to Non-secure state.

Window programming uses a single write port that writes all fields of one window at once. The write is accepted only while the block is in Secure state. A build parameter removes the security feature. The block then stays in Non-secure state permanently and reports every address as Non-secure.

Top module: `sec_attr_checker`

## Requirements
- R1: Attribute codes are 2'b00 Secure, 2'b01 Callable and 2'b10 Non-secure; a stored code of 2'b11 is reported as Secure. One cycle after an access with `acc_valid` high, `attr_o` shows the code of the enabled window whose bounds contain the address, both bounds inclusive. `attr_o` holds its value while `acc_valid` is low.
- R2: When several enabled windows contain the address, the lowest index wins. Disabled windows never match. An address with no match is reported as Secure.
- R3: In Secure state no access faults, whatever its attribute.
- R4: In Non-secure state an access to a Secure or Callable address raises `fault_o` for exactly one cycle, together with that address's attribute on `attr_o`. Accesses to Non-secure addresses do not fault.
- R5: In Non-secure state, an instruction fetch (`acc_kind` 2'b10) with `gw_opcode` high from a Callable address pulses `enter_sec_o` for one cycle. The same clock edge sets `sec_state_o` to 1 and raises no fault.
- R6: A gateway fetch from a Secure address never changes the state and never pulses `enter_sec_o`; in Non-secure state it faults. A gateway fetch made in Secure state does not pulse `enter_sec_o`.
- R7: With `SEC_EN`=1, `sec_state_o` is 1 after reset. With `SEC_EN`=0, `sec_state_o` stays 0, `attr_o` always reads 2'b10, and no fault or entry is ever signalled.
- R8: A `ns_return` pulse in Secure state clears `sec_state_o` at the next clock edge.
- R9: A window write in Secure state takes effect from the next cycle. A write in Non-secure state leaves every window unchanged and pulses `cfg_reject_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_kind | input | 2 | 2'b00 data read, 2'b01 data write, 2'b10 instruction fetch |
| gw_opcode | input | 1 | The fetched word is a gateway opcode |
| ns_return | input | 1 | Pulse requesting a return to Non-secure state |
| cfg_we | input | 1 | Window write strobe |
| cfg_idx | input | IDX_W | Window index to write |
| cfg_base | input | ADDR_W | Inclusive lower bound |
| cfg_limit | input | ADDR_W | Inclusive upper bound |
| cfg_en | input | 1 | Window enable |
| cfg_attr | input | 2 | Window attribute code |
| attr_o | output | 2 | Registered attribute of the last access |
| fault_o | output | 1 | Security fault pulse |
| enter_sec_o | output | 1 | Pulse: switch to Secure state |
| sec_state_o | output | 1 | 1 = Secure, 0 = Non-secure |
| cfg_reject_o | output | 1 | Pulse: a window write was refused |

## Verification
The state assertions take two things for granted. `ns_return` is a single pulse, and it is never given in the same cycle as a gateway fetch that would enter Secure state. The pulse-to-state checks depend on this. The bench raises `ns_return` for one cycle, only in Secure state and with no access present. It drives every access and window write as an isolated one-cycle strobe, with idle cycles between, so each registered response can be sampled on its own.

// File: rtl/sac_pkg.sv
package sac_pkg;
   typedef enum logic [1:0] {
      ATTR_S   = 2'b00,
      ATTR_NSC = 2'b01,
      ATTR_NS  = 2'b10,
      ATTR_RSV = 2'b11
   } attr_e;

   typedef enum logic [1:0] {
      ACC_RD    = 2'b00,
      ACC_WR    = 2'b01,
      ACC_FETCH = 2'b10
   } kind_e;

   function automatic attr_e norm_attr(input logic [1:0] code);
      return (code == ATTR_RSV) ? ATTR_S : attr_e'(code);
   endfunction
endpackage

// File: rtl/sac_region_file.sv
module sac_region_file #(
   parameter int N_REGIONS = 8,
   parameter int ADDR_W    = 32,
   localparam int IDX_W    = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic [ADDR_W-1:0]      wr_base,
   input  logic [ADDR_W-1:0]      wr_limit,
   input  logic                   wr_on,
   input  logic [1:0]             wr_attr,
   input  logic [ADDR_W-1:0]      look_addr,
   output logic [N_REGIONS-1:0]   hit_vec,
   output logic [2*N_REGIONS-1:0] attr_flat
);
   for (genvar g = 0; g < N_REGIONS; g++) begin : g_rgn
      logic [ADDR_W-1:0] base_q, limit_q;
      logic              on_q;
      logic [1:0]        attr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
            on_q    <= 1'b0;
            attr_q  <= 2'b00;
         end else if (wr_en && wr_idx == IDX_W'(g)) begin
            base_q  <= wr_base;
            limit_q <= wr_limit;
            on_q    <= wr_on;
            attr_q  <= wr_attr;
         end
      end

      assign hit_vec[g] = on_q && (look_addr >= base_q) && (look_addr <= limit_q);
      assign attr_flat[2*g +: 2] = attr_q;
   end
endmodule

// File: rtl/sac_prio_sel.sv
module sac_prio_sel
   import sac_pkg::*;
#(
   parameter int N_REGIONS = 8
) (
   input  logic [N_REGIONS-1:0]   hit_vec,
   input  logic [2*N_REGIONS-1:0] attr_flat,
   output attr_e                  attr_o,
   output logic                   any_hit_o
);
   always_comb begin
      attr_o    = ATTR_S;
      any_hit_o = 1'b0;
      for (int i = N_REGIONS - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            attr_o    = norm_attr(attr_flat[2*i +: 2]);
            any_hit_o = 1'b1;
         end
      end
   end

   // R2
   always_comb begin
      no_hit_default_chk: assert (any_hit_o || hit_vec != '0 || attr_o == ATTR_S);
   end
endmodule

// File: rtl/sac_state.sv
module sac_state #(
   parameter bit SEC_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enter_i,
   input  logic leave_i,
   output logic sec_o
);
   if (SEC_EN) begin : g_tracked
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                sec_o <= 1'b1;
         else if (enter_i && !sec_o) sec_o <= 1'b1;
         else if (leave_i && sec_o)  sec_o <= 1'b0;
      end

      // R5
      rose_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sec_o) |-> $past(enter_i));
      // R8
      fell_needs_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(sec_o) |-> $past(leave_i));
   end else begin : g_fixed_ns
      logic unused_req;
      assign unused_req = enter_i ^ leave_i ^ clk;
      assign sec_o = 1'b0;

      // R7
      always_comb begin
         stays_ns_chk: assert (!sec_o || !rst_n);
      end
   end
endmodule

// File: rtl/sec_attr_checker.sv
module sec_attr_checker
   import sac_pkg::*;
#(
   parameter int  N_REGIONS = 8,
   parameter int  ADDR_W    = 32,
   parameter bit  SEC_EN    = 1'b1,
   localparam int IDX_W     = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_kind,
   input  logic              gw_opcode,
   input  logic              ns_return,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] cfg_limit,
   input  logic              cfg_en,
   input  logic [1:0]        cfg_attr,
   output logic [1:0]        attr_o,
   output logic              fault_o,
   output logic              enter_sec_o,
   output logic              sec_state_o,
   output logic              cfg_reject_o
);
   if (N_REGIONS < 1 || N_REGIONS > 16) begin : g_bad_regions
      $error("N_REGIONS must be within 1..16");
   end
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr
      $error("ADDR_W must be within 8..64");
   end

   localparam attr_e RST_ATTR = SEC_EN ? ATTR_S : ATTR_NS;

   logic [N_REGIONS-1:0]   hit_vec;
   logic [2*N_REGIONS-1:0] attr_flat;
   attr_e                  sel_attr, eff_attr;
   logic                   any_hit, sec_q;
   logic                   cfg_ok, cfg_bad, is_entry, is_fault, is_gw_fetch;
   logic [1:0]             attr_q;
   logic                   fault_q, enter_q, rej_q;

   assign cfg_ok  = cfg_we && sec_q;
   assign cfg_bad = cfg_we && !sec_q;

   sac_region_file #(.N_REGIONS(N_REGIONS), .ADDR_W(ADDR_W)) rf_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_ok), .wr_idx(cfg_idx), .wr_base(cfg_base),
      .wr_limit(cfg_limit), .wr_on(cfg_en), .wr_attr(cfg_attr),
      .look_addr(acc_addr), .hit_vec(hit_vec), .attr_flat(attr_flat)
   );

   sac_prio_sel #(.N_REGIONS(N_REGIONS)) sel_i (
      .hit_vec(hit_vec), .attr_flat(attr_flat),
      .attr_o(sel_attr), .any_hit_o(any_hit)
   );

   if (SEC_EN) begin : g_attr_live
      assign eff_attr = sel_attr;
   end else begin : g_attr_flat
      logic unused_sel;
      assign unused_sel = ^{sel_attr, any_hit};
      assign eff_attr   = ATTR_NS;
   end

   assign is_gw_fetch = (acc_kind == ACC_FETCH) && gw_opcode;
   assign is_entry = acc_valid && !sec_q && is_gw_fetch && (eff_attr == ATTR_NSC);
   assign is_fault = acc_valid && !sec_q && (eff_attr != ATTR_NS) && !is_entry;

   sac_state #(.SEC_EN(SEC_EN)) st_i (
      .clk(clk), .rst_n(rst_n),
      .enter_i(is_entry), .leave_i(ns_return), .sec_o(sec_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attr_q  <= RST_ATTR;
         fault_q <= 1'b0;
         enter_q <= 1'b0;
         rej_q   <= 1'b0;
      end else begin
         if (acc_valid) attr_q <= eff_attr;
         fault_q <= is_fault;
         enter_q <= is_entry;
         rej_q   <= cfg_bad;
      end
   end

   assign attr_o       = attr_q;
   assign fault_o      = fault_q;
   assign enter_sec_o  = enter_q;
   assign sec_state_o  = sec_q;
   assign cfg_reject_o = rej_q;

   // R4
   fault_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> attr_o != ATTR_NS);
   // R4
   fault_keeps_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> !sec_state_o);
   // R5
   entry_lands_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enter_sec_o |-> sec_state_o && attr_o == ATTR_NSC);
   // R5
   entry_not_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fault_o && enter_sec_o));
   // R9
   reject_only_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_reject_o |-> !$past(sec_q));
   // R3
   secure_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sec_q) |-> !fault_o);
endmodule

// File: tb/sec_attr_checker_tb_top.sv
module sec_attr_checker_tb_top;
   localparam int AW = 32;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [1:0] acc_kind = 2'b00;
   logic gw_opcode = 1'b0;
   logic ns_return = 1'b0;
   logic cfg_we = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [AW-1:0] cfg_base = '0, cfg_limit = '0;
   logic cfg_en = 1'b0;
   logic [1:0] cfg_attr = 2'b00;

   logic [1:0] attr_o, d2_attr;
   logic fault_o, enter_o, sec_o, rej_o;
   logic d2_fault, d2_enter, d2_sec, d2_rej;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sec_attr_checker #(.N_REGIONS(8), .ADDR_W(AW), .SEC_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_kind(acc_kind), .gw_opcode(gw_opcode), .ns_return(ns_return),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
      .cfg_limit(cfg_limit), .cfg_en(cfg_en), .cfg_attr(cfg_attr),
      .attr_o(attr_o), .fault_o(fault_o), .enter_sec_o(enter_o),
      .sec_state_o(sec_o), .cfg_reject_o(rej_o));

   sec_attr_checker #(.N_REGIONS(8), .ADDR_W(AW), .SEC_EN(1'b0)) dut_ns_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_kind(acc_kind), .gw_opcode(gw_opcode), .ns_return(ns_return),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
      .cfg_limit(cfg_limit), .cfg_en(cfg_en), .cfg_attr(cfg_attr),
      .attr_o(d2_attr), .fault_o(d2_fault), .enter_sec_o(d2_enter),
      .sec_state_o(d2_sec), .cfg_reject_o(d2_rej));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic expect_out(input string req, input int ea, input bit ef,
                             input bit ee, input bit es);
      check(attr_o == 2'(ea), req, "attr", int'(attr_o), ea);
      check(fault_o == ef, req, "fault", int'(fault_o), int'(ef));
      check(enter_o == ee, req, "enter", int'(enter_o), int'(ee));
      check(sec_o == es, req, "state", int'(sec_o), int'(es));
   endtask

   task automatic access(input logic [AW-1:0] a, input logic [1:0] k, input bit gw);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_kind = k; gw_opcode = gw;
      @(negedge clk);
      acc_valid = 1'b0; gw_opcode = 1'b0;
   endtask

   task automatic cfg_write(input int idx, input logic [AW-1:0] b,
                            input logic [AW-1:0] l, input bit en, input logic [1:0] at);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_base = b; cfg_limit = l;
      cfg_en = en; cfg_attr = at;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_out("R7", 0, 1'b0, 1'b0, 1'b1);
      check(rej_o == 1'b0, "R9", "reset reject", int'(rej_o), 0);
   endtask

   task automatic t_disabled_variant;
      access(32'h0, 2'b00, 1'b0);
      check(d2_sec == 1'b0, "R7", "off state", int'(d2_sec), 0);
      check(d2_attr == 2'b10, "R7", "off attr", int'(d2_attr), 2);
      check(d2_fault == 1'b0, "R7", "off fault", int'(d2_fault), 0);
      expect_out("R2", 0, 1'b0, 1'b0, 1'b1);
      cfg_write(5, 32'hF000, 32'hF0FF, 1'b0, 2'b10);
      check(d2_rej == 1'b1, "R7", "off reject", int'(d2_rej), 1);
      check(rej_o == 1'b0, "R9", "secure write accepted", int'(rej_o), 0);
   endtask

   task automatic t_program;
      cfg_write(0, 32'h1000, 32'h1FFF, 1'b1, 2'b10);
      cfg_write(1, 32'h2000, 32'h20FF, 1'b1, 2'b01);
      cfg_write(2, 32'h3000, 32'h3FFF, 1'b0, 2'b10);
      cfg_write(3, 32'h1800, 32'h18FF, 1'b1, 2'b01);
      cfg_write(4, 32'h4000, 32'h4FFF, 1'b1, 2'b11);
      cfg_write(7, 32'h5000, 32'h5FFF, 1'b1, 2'b10);
      check(rej_o == 1'b0, "R9", "program reject", int'(rej_o), 0);
   endtask

   task automatic t_secure_classify;
      access(32'h1800, 2'b00, 1'b0); expect_out("R2", 2, 1'b0, 1'b0, 1'b1);
      access(32'h2000, 2'b01, 1'b0); expect_out("R3", 1, 1'b0, 1'b0, 1'b1);
      access(32'h3000, 2'b00, 1'b0); expect_out("R2", 0, 1'b0, 1'b0, 1'b1);
      access(32'h9000, 2'b00, 1'b0); expect_out("R2", 0, 1'b0, 1'b0, 1'b1);
      access(32'h4000, 2'b00, 1'b0); expect_out("R1", 0, 1'b0, 1'b0, 1'b1);
      access(32'h5FFF, 2'b00, 1'b0); expect_out("R1", 2, 1'b0, 1'b0, 1'b1);
      access(32'h5000, 2'b00, 1'b0); expect_out("R1", 2, 1'b0, 1'b0, 1'b1);
      access(32'h6000, 2'b01, 1'b0); expect_out("R1", 0, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      check(attr_o == 2'b00, "R1", "attr holds", int'(attr_o), 0);
      access(32'h2004, 2'b10, 1'b1); expect_out("R6", 1, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_return;
      @(negedge clk);
      ns_return = 1'b1;
      @(negedge clk);
      ns_return = 1'b0;
      check(sec_o == 1'b0, "R8", "after return", int'(sec_o), 0);
   endtask

   task automatic t_nonsecure;
      access(32'h1000, 2'b00, 1'b0); expect_out("R4", 2, 1'b0, 1'b0, 1'b0);
      access(32'h0000, 2'b01, 1'b0); expect_out("R4", 0, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      check(fault_o == 1'b0, "R4", "fault pulse width", int'(fault_o), 0);
      access(32'h2010, 2'b00, 1'b0); expect_out("R4", 1, 1'b1, 1'b0, 1'b0);
      access(32'h2010, 2'b10, 1'b0); expect_out("R4", 1, 1'b1, 1'b0, 1'b0);
      cfg_write(0, 32'h1000, 32'h1FFF, 1'b1, 2'b00);
      check(rej_o == 1'b1, "R9", "ns write flagged", int'(rej_o), 1);
      access(32'h1000, 2'b00, 1'b0); expect_out("R9", 2, 1'b0, 1'b0, 1'b0);
      access(32'h4000, 2'b10, 1'b1); expect_out("R6", 0, 1'b1, 1'b0, 1'b0);
      access(32'h2004, 2'b10, 1'b1); expect_out("R5", 1, 1'b0, 1'b1, 1'b1);
      @(negedge clk);
      check(enter_o == 1'b0, "R5", "enter pulse width", int'(enter_o), 0);
   endtask

   task automatic t_secure_reprogram;
      cfg_write(2, 32'h3000, 32'h3FFF, 1'b1, 2'b10);
      check(rej_o == 1'b0, "R9", "secure write", int'(rej_o), 0);
      access(32'h3000, 2'b00, 1'b0); expect_out("R9", 2, 1'b0, 1'b0, 1'b1);
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      t_reset();
      t_disabled_variant();
      t_program();
      t_secure_classify();
      t_return();
      t_nonsecure();
      t_secure_reprogram();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule